// File: doc/BRIEF.md
# Flash Controller Event and Recovery Unit

This block gathers eight single-cycle event pulses from a serial flash controller and latches each one in a raw status register until software clears it by writing ones. A mask register, where a set bit silences its source, produces a masked status view, and the OR of that view drives one level-sensitive interrupt line. Software reaches every register through a simple 32-bit register port. A write takes effect on the clock edge. Reads are combinational from the address.

The unit also holds the FIFO threshold settings and shows the live FIFO flags, the FIFO levels and the sequencer busy flag. A recovery command raises a reset strobe toward the sequencer and both FIFOs for a fixed number of cycles. The command bit reads as one while the strobe is active and then returns to zero by itself. The serial sequencer and the FIFOs sit outside this block.

Top module: `flash_evt_unit`

## Requirements
- R1: After reset the mask register (offset 0x04) reads 0xFF, raw status reads 0, the threshold register reads 0, the recovery bit reads 0, and irqOut is low.
- R2: A one-cycle pulse on evtIn[i] sets bit i of raw status (offset 0x28) on the next clock edge, and the bit holds until it is cleared. Bit order from 0 is: rx full, rx underflow, tx overflow, tx empty, transfer done, bus error, non-serial error, DMA done.
- R3: Writing to the clear register (offset 0x08) clears each raw bit whose write-data bit is 1. Zero bits leave their raw bits unchanged, and the clear register reads 0.
- R4: When an event pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R5: In the mask register, bit i = 1 disables source i. Masked status (offset 0x1C) reads raw & ~mask. A masked event still latches in raw status.
- R6: irqOut is high exactly when masked status is nonzero.
- R7: Writing data bit 0 = 1 to the recovery register (offset 0x10) drives recoverOut high for exactly 4 cycles, starting at the edge that takes the write. Bit 0 of that register reads 1 for the same 4 cycles and 0 afterwards. Writing 0 to bit 0 has no effect, and so does writing 1 again while recovery is already running.
- R8: Recovery leaves the mask register and raw status unchanged.
- R9: The threshold register (offset 0x0C) holds the tx threshold at bits 4:0 and the rx threshold at bits 12:8. The outputs txThresh and rxThresh follow it.
- R10: FIFO status (offset 0x20) reads tx full at bit 0, tx empty at bit 1, rx empty at bit 2, rx full at bit 3, the tx level at bits 12:8 and the rx level at bits 20:16, all taken live from the inputs.
- R11: Busy status (offset 0x24) bit 0 equals seqBusy.
- R12: Unmapped offsets read 0. Writes to the read-only offsets 0x1C, 0x20, 0x24 and 0x28 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Write strobe, taken at the clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| evtIn | input | 8 | Single-cycle event pulses |
| txFull | input | 1 | Tx FIFO full |
| txEmpty | input | 1 | Tx FIFO empty |
| rxEmpty | input | 1 | Rx FIFO empty |
| rxFull | input | 1 | Rx FIFO full |
| txLevel | input | 5 | Tx FIFO level |
| rxLevel | input | 5 | Rx FIFO level |
| seqBusy | input | 1 | Sequencer busy |
| irqOut | output | 1 | Level interrupt |
| recoverOut | output | 1 | Sequencer and FIFO reset strobe |
| txThresh | output | 5 | Tx FIFO threshold |
| rxThresh | output | 5 | Rx FIFO threshold |

## Verification
The bench sends an event and a clear for the same bit in one cycle. A design in which the clear wins would lose that event. It latches events while they are masked and then unmasks them: a design that gates latching with the mask would never raise irqOut, and a design that ignores the mask would interrupt too early. It counts the recovery strobe cycle by cycle. This catches a strobe that lasts 3 or 5 cycles, a strobe that restarts on a second write, and a recovery that resets the mask. It also writes to read-only and unmapped offsets and reads every packed status field, so a shifted field or a write that leaks into the wrong register shows up.

// File: rtl/flash_evt_pkg.sv
package flash_evt_pkg;
  localparam int EVT_W  = 8;
  localparam int LVL_W  = 5;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_THR    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_RECOV  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MSTAT  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_FIFO   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_BUSY   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h28;

  typedef enum logic [3:0] {
    RD_NONE, RD_MASK, RD_THR, RD_RECOV, RD_MSTAT, RD_FIFO, RD_BUSY, RD_RAW
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrClr;
    logic   wrThr;
    logic   recovActive;
    rdSel_e rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/flash_evt_ctl.sv
module flash_evt_ctl
  import flash_evt_pkg::*;
#(
  parameter int RECOVER_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output ctlStrobe_t        stb,
  output logic              recoverOut
);
  localparam int CNT_W = $clog2(RECOVER_CYC + 1);

  logic [CNT_W-1:0] recCnt;
  logic             recStart;

  assign recStart = busWrEn && (busAddr == OFS_RECOV) && busWrData[0] && (recCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          recCnt <= '0;
    else if (recStart)  recCnt <= CNT_W'(RECOVER_CYC);
    else if (recCnt != '0) recCnt <= recCnt - 1'b1;
  end

  assign recoverOut = (recCnt != '0);

  always_comb begin
    stb.wrMask      = busWrEn && (busAddr == OFS_MASK);
    stb.wrClr       = busWrEn && (busAddr == OFS_CLR);
    stb.wrThr       = busWrEn && (busAddr == OFS_THR);
    stb.recovActive = recoverOut;
    unique case (busAddr)
      OFS_MASK:  stb.rdSel = RD_MASK;
      OFS_THR:   stb.rdSel = RD_THR;
      OFS_RECOV: stb.rdSel = RD_RECOV;
      OFS_MSTAT: stb.rdSel = RD_MSTAT;
      OFS_FIFO:  stb.rdSel = RD_FIFO;
      OFS_BUSY:  stb.rdSel = RD_BUSY;
      OFS_RAW:   stb.rdSel = RD_RAW;
      default:   stb.rdSel = RD_NONE;
    endcase
  end

  // R7
  recover_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recoverOut) |-> $past(busWrEn && busAddr == OFS_RECOV && busWrData[0]));

  // R7
  recover_no_retrigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(recoverOut) && recoverOut) |-> (recCnt == $past(recCnt) - 1'b1));
endmodule

// File: rtl/flash_evt_dp.sv
module flash_evt_dp
  import flash_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic              txFull,
  input  logic              txEmpty,
  input  logic              rxEmpty,
  input  logic              rxFull,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              seqBusy,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut,
  output logic [LVL_W-1:0]  txThresh,
  output logic [LVL_W-1:0]  rxThresh
);
  logic [EVT_W-1:0] rawQ;
  logic [EVT_W-1:0] maskQ;
  logic [EVT_W-1:0] clrBits;
  logic [EVT_W-1:0] maskedStat;
  logic [LVL_W-1:0] txThrQ;
  logic [LVL_W-1:0] rxThrQ;

  assign clrBits = stb.wrClr ? busWrData[EVT_W-1:0] : '0;

  generate
    for (genvar i = 0; i < EVT_W; i++) begin : gEvt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          rawQ[i] <= 1'b0;
        else if (evtIn[i])  rawQ[i] <= 1'b1;
        else if (clrBits[i]) rawQ[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '1;
      txThrQ <= '0;
      rxThrQ <= '0;
    end else begin
      if (stb.wrMask) maskQ <= busWrData[EVT_W-1:0];
      if (stb.wrThr) begin
        txThrQ <= busWrData[LVL_W-1:0];
        rxThrQ <= busWrData[8 +: LVL_W];
      end
    end
  end

  assign maskedStat = rawQ & ~maskQ;
  assign irqOut     = |maskedStat;
  assign txThresh   = txThrQ;
  assign rxThresh   = rxThrQ;

  always_comb begin
    busRdData = '0;
    unique case (stb.rdSel)
      RD_MASK:  busRdData[EVT_W-1:0] = maskQ;
      RD_THR: begin
        busRdData[LVL_W-1:0]  = txThrQ;
        busRdData[8 +: LVL_W] = rxThrQ;
      end
      RD_RECOV: busRdData[0] = stb.recovActive;
      RD_MSTAT: busRdData[EVT_W-1:0] = maskedStat;
      RD_FIFO: begin
        busRdData[3:0]         = {rxFull, rxEmpty, txEmpty, txFull};
        busRdData[8 +: LVL_W]  = txLevel;
        busRdData[16 +: LVL_W] = rxLevel;
      end
      RD_BUSY:  busRdData[0] = seqBusy;
      RD_RAW:   busRdData[EVT_W-1:0] = rawQ;
      default:  busRdData = '0;
    endcase
  end

  // R2
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((rawQ & $past(evtIn)) == $past(evtIn)));

  // R3
  clear_applies_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrClr |=> ((rawQ & $past(busWrData[EVT_W-1:0] & ~evtIn)) == '0));

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrMask |=> $stable(maskQ));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(evtIn) != '0 || $past(stb.wrMask)));
endmodule

// File: rtl/flash_evt_unit.sv
module flash_evt_unit
  import flash_evt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic [7:0]  evtIn,
  input  logic        txFull,
  input  logic        txEmpty,
  input  logic        rxEmpty,
  input  logic        rxFull,
  input  logic [4:0]  txLevel,
  input  logic [4:0]  rxLevel,
  input  logic        seqBusy,
  output logic        irqOut,
  output logic        recoverOut,
  output logic [4:0]  txThresh,
  output logic [4:0]  rxThresh
);
  ctlStrobe_t stb;

  flash_evt_ctl #(.RECOVER_CYC(4)) uCtl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .stb(stb), .recoverOut(recoverOut)
  );

  flash_evt_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWrData(busWrData), .evtIn(evtIn),
    .txFull(txFull), .txEmpty(txEmpty), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .txLevel(txLevel), .rxLevel(rxLevel), .seqBusy(seqBusy),
    .busRdData(busRdData), .irqOut(irqOut), .txThresh(txThresh), .rxThresh(rxThresh)
  );
endmodule

// File: tb/sim_flash_evt_unit.sv
module sim_flash_evt_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  evtIn = '0;
  logic        txFull = 0, txEmpty = 0, rxEmpty = 0, rxFull = 0, seqBusy = 0;
  logic [4:0]  txLevel = '0, rxLevel = '0;
  logic        irqOut, recoverOut;
  logic [4:0]  txThresh, rxThresh;

  int checks = 0;
  int failures = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  event        chkEv;

  always #10 clk = ~clk;

  flash_evt_unit u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the read port
  initial forever begin
    @(chkEv);
    #2;
    check(tagQ.pop_front(), busRdData, expQ.pop_front());
  end

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    -> chkEv;
    #5;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] e);
    evtIn = e;
    @(negedge clk);
    evtIn = '0;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    busRead(8'h04, 32'hFF, "R1 mask");
    busRead(8'h28, 32'h0, "R1 raw");
    busRead(8'h0C, 32'h0, "R1 thresh");
    busRead(8'h10, 32'h0, "R1 recov");
    check("R1 irq", irqOut, 0);

    // R2 latch, R5 masked still latches, R6 no irq while masked
    pulse(8'h11);
    busRead(8'h28, 32'h11, "R2 raw latch");
    busRead(8'h1C, 32'h0, "R5 masked view all masked");
    check("R6 irq masked", irqOut, 0);
    pulse(8'h80);
    busRead(8'h28, 32'h91, "R2 raw hold and accumulate");

    // R5 unmask bit4 -> R6 irq
    busWrite(8'h04, 32'hEF);
    busRead(8'h1C, 32'h10, "R5 masked status");
    check("R6 irq on", irqOut, 1);

    // R3 clear with zeros elsewhere; clear reads 0
    busWrite(8'h08, 32'h10);
    busRead(8'h28, 32'h81, "R3 clear one bit");
    check("R6 irq off", irqOut, 0);
    busRead(8'h08, 32'h0, "R3 clear reads 0");

    // R4 event and clear same cycle: event wins
    evtIn = 8'h01;
    busWrite(8'h08, 32'h81);
    evtIn = '0;
    busRead(8'h28, 32'h01, "R4 set wins");

    // R12 writes to read-only offsets ignored, unmapped reads 0
    busWrite(8'h28, 32'hFF);
    busWrite(8'h1C, 32'hFF);
    busWrite(8'h20, 32'hFF);
    busWrite(8'h24, 32'hFF);
    busRead(8'h28, 32'h01, "R12 raw unchanged");
    busRead(8'h04, 32'hEF, "R12 mask unchanged");
    busWrite(8'h30, 32'hFFFF_FFFF);
    busRead(8'h30, 32'h0, "R12 unmapped read");
    busRead(8'h0C, 32'h0, "R12 thresh unchanged");

    // R9 thresholds
    busWrite(8'h0C, 32'hFFFF_1A15);
    busRead(8'h0C, 32'h0000_1A15, "R9 thresh readback");
    check("R9 txThresh", txThresh, 5'h15);
    check("R9 rxThresh", rxThresh, 5'h1A);

    // R10 FIFO status packing
    txFull = 1; txEmpty = 0; rxEmpty = 1; rxFull = 0; txLevel = 5'h13; rxLevel = 5'h0B;
    busRead(8'h20, 32'h000B_1305, "R10 fifo pattern A");
    txFull = 0; txEmpty = 1; rxEmpty = 0; rxFull = 1; txLevel = 5'h00; rxLevel = 5'h1F;
    busRead(8'h20, 32'h001F_000A, "R10 fifo pattern B");

    // R11 busy
    seqBusy = 1;
    busRead(8'h24, 32'h1, "R11 busy");
    seqBusy = 0;
    busRead(8'h24, 32'h0, "R11 idle");

    // R7 write of 0 has no effect
    busWrite(8'h10, 32'hFFFF_FFFE);
    check("R7 zero write", recoverOut, 0);

    // R7 recovery strobe length, no retrigger; R8 mask/raw preserved
    busWrite(8'h10, 32'h1);
    check("R7 recov cycle1", recoverOut, 1);
    busRead(8'h10, 32'h1, "R7 recov reads 1");
    busWrite(8'h10, 32'h1);
    check("R7 recov cycle3", recoverOut, 1);
    @(negedge clk);
    check("R7 recov cycle4", recoverOut, 1);
    @(negedge clk);
    check("R7 recov ended", recoverOut, 0);
    busRead(8'h10, 32'h0, "R7 recov self-cleared");
    busRead(8'h04, 32'hEF, "R8 mask kept");
    busRead(8'h28, 32'h01, "R8 raw kept");

    // R6 full mask open with several pending
    pulse(8'h6C);
    busWrite(8'h04, 32'h00);
    busRead(8'h1C, 32'h6D, "R5 masked all open");
    check("R6 irq multi", irqOut, 1);
    busWrite(8'h08, 32'hFF);
    check("R6 irq cleared", irqOut, 0);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule